// File: doc/BRIEF.md
# Dual-Plane Pixel Colour Selector

This block is a streaming stage that sits between the memory fetch of an overlay framebuffer and the display output. For every source pixel it receives three values together: an 8-bit palette index, a 32-bit direct-colour word and a 32-bit control word. The top byte of the control word chooses the colour source for that pixel. One tag value selects the direct-colour word. Every other value makes the stage look the index up in an external palette RAM, which has one cycle of read latency.

The source stream always carries 1024 pixels per line, whatever the active width. The stage counts the column and the row itself. It drops pixels that lie beyond the configured active width and emits a 32-bit packed colour for each visible pixel. Each output pixel carries a start-of-line flag and a start-of-frame flag. A static input chooses RGB or BGR packing, and this choice applies to both colour sources. Valid/ready handshakes on both sides let back-pressure stall the whole pipeline. No pixel is lost or repeated.

Top module: `pxm_selector`

## Requirements
- R1: During reset and on the first cycle after it, `out_valid` is 0, `in_ready` is 1 and `pal_rd_en` is 0.
- R2: A pixel whose `in_ctrl[31:24]` is any value other than 8'h03 takes its colour from palette entry `in_index`. The palette returns {red[23:16], green[15:8], blue[7:0]}.
- R3: A pixel whose `in_ctrl[31:24]` equals 8'h03 takes its colour from `in_direct`, with blue in bits 23:16, green in bits 15:8 and red in bits 7:0. Bits 31:24 of `in_direct` and the palette data have no effect on such a pixel.
- R4: With `cfg_bgr`=0 the output is {8'h00, R, G, B}. With `cfg_bgr`=1 it is {8'h00, B, G, R}. The choice applies to both colour sources.
- R5: The input stream has a fixed stride of 1024 pixels per line. Pixels at columns at or beyond `cfg_width` are accepted but produce no output and no palette read. Every column below `cfg_width` produces exactly one output, in order.
- R6: `out_sol` is 1 on the output pixel from column 0. `out_sof` is 1 only on column 0 of row 0. Rows wrap to 0 after row `cfg_height`-1.
- R7: A palette read (`pal_rd_en`=1, `pal_rd_addr`=`in_index`) is issued in the cycle that each visible pixel is accepted, and in no other cycle.
- R8: While `out_valid`=1 and `out_ready`=0, the output pixel and its flags hold unchanged.
- R9: While `out_ready` is held at 1, `in_ready` stays at 1, so the stage runs at one pixel per cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_bgr | input | 1 | 0: RGB packing, 1: BGR packing (static) |
| cfg_width | input | 11 | Active pixels per line, 1..1024 (static) |
| cfg_height | input | 10 | Active lines per frame, 1..768 (static) |
| in_valid | input | 1 | Source pixel valid |
| in_ready | output | 1 | Stage can accept a source pixel |
| in_index | input | 8 | Palette index of the pixel |
| in_direct | input | 32 | Direct-colour word, blue-first in bits 23:0 |
| in_ctrl | input | 32 | Control word, colour source tag in bits 31:24 |
| pal_rd_en | output | 1 | Palette read strobe |
| pal_rd_addr | output | 8 | Palette read address |
| pal_rd_data | input | 24 | Palette colour, valid one cycle after a read, held otherwise |
| out_valid | output | 1 | Output pixel valid |
| out_ready | input | 1 | Sink accepts the output pixel |
| out_pixel | output | 32 | Packed output colour |
| out_sol | output | 1 | Output pixel is the first of a line |
| out_sof | output | 1 | Output pixel is the first of a frame |

## Verification
Random control words are mixed with forced tags near the direct tag (0x02, 0x04, 0x83, 0xFF), so a decoder that looks at part of the tag byte picks the wrong colour source. Random direct words with random top bytes, compared against a palette filled with different random colours, show any swapped channel or any leak of the wrong source. Segments with a full 1024-pixel width, a one-pixel width and odd widths, each with several heights, both packings and different stall rates, test that the right pixels are dropped, that the flags fall on the right pixels and that nothing is lost or repeated under back-pressure. A segment with no stalls tests that the stage runs at full rate.

// File: rtl/pxm_pkg.sv
// Shared constants and types for the pixel colour selector.
// Assumes 8-bit colour channels and a 32-bit packed output word.
package pxm_pkg;
    localparam int CH_W  = 8;
    localparam int PIX_W = 4 * CH_W;
    localparam logic [CH_W-1:0] DIRECT_TAG = 8'h03;

    typedef logic [CH_W-1:0] chan_t;

    typedef struct packed {
        chan_t r;
        chan_t g;
        chan_t b;
    } rgb_t;
endpackage

// File: rtl/pxm_pos_counter.sv
// Column/row tracker for the source stream.
// Assumes a fixed source stride of STRIDE pixels per line and that cfg_width
// and cfg_height stay constant outside reset (cfg_height >= 1).
module pxm_pos_counter #(
    parameter int STRIDE = 1024,
    parameter int MAX_H  = 768,
    localparam int XW = $clog2(STRIDE),
    localparam int YW = $clog2(MAX_H + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          step,
    input  logic [XW:0]   cfg_width,
    input  logic [YW-1:0] cfg_height,
    output logic          visible,
    output logic          line_start,
    output logic          frame_start
);
    logic [XW-1:0] col_q;
    logic [YW-1:0] row_q;
    logic          col_last;
    logic          row_last;

    assign col_last    = (col_q == XW'(STRIDE - 1));
    assign row_last    = (row_q == (cfg_height - YW'(1)));
    assign visible     = ({1'b0, col_q} < cfg_width);
    assign line_start  = (col_q == '0);
    assign frame_start = (col_q == '0) && (row_q == '0);

    // Advance the column on each accepted pixel, the row at the end of a stride.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            col_q <= '0;
            row_q <= '0;
        end else if (step) begin
            col_q <= col_last ? '0 : col_q + XW'(1);
            if (col_last) begin
                row_q <= row_last ? '0 : row_q + YW'(1);
            end
        end
    end

    p_row_range_r6: assert property (@(posedge clk) disable iff (!rst_n)
        row_q < cfg_height);
endmodule

// File: rtl/pxm_mode_decode.sv
// Per-pixel colour source decode.
// Selects direct colour when the control tag equals DIRECT_TAG and
// extracts the blue-first channels of the direct-colour word.
module pxm_mode_decode
    import pxm_pkg::*;
(
    input  chan_t              ctrl_tag,
    input  logic [3*CH_W-1:0]  direct_word,
    output logic               use_direct,
    output rgb_t               direct_rgb
);
    // Compare the full tag byte; any other value means palette colour.
    always_comb begin
        use_direct = (ctrl_tag == DIRECT_TAG);
    end

    // Blue sits in the top channel, red in the bottom one.
    always_comb begin
        direct_rgb.b = direct_word[2*CH_W +: CH_W];
        direct_rgb.g = direct_word[CH_W   +: CH_W];
        direct_rgb.r = direct_word[0      +: CH_W];
    end
endmodule

// File: rtl/pxm_pack.sv
// Colour source merge and output packing.
// Picks the direct or palette colour and places the channels in RGB or BGR
// order below a zero top byte.
module pxm_pack
    import pxm_pkg::*;
(
    input  logic             use_direct,
    input  rgb_t             direct_rgb,
    input  rgb_t             pal_rgb,
    input  logic             bgr,
    output logic [PIX_W-1:0] pixel
);
    rgb_t  src;
    chan_t ch [3];

    // Merge the two colour sources.
    always_comb begin
        src   = use_direct ? direct_rgb : pal_rgb;
        ch[0] = src.r;
        ch[1] = src.g;
        ch[2] = src.b;
    end

    assign pixel[PIX_W-1 -: CH_W] = '0;

    // Channel gi lands at slot 2-gi in RGB order; BGR mirrors the order.
    for (genvar gi = 0; gi < 3; gi++) begin : g_slot
        assign pixel[(2-gi)*CH_W +: CH_W] = bgr ? ch[2-gi] : ch[gi];
    end
endmodule

// File: rtl/pxm_selector.sv
// Dual-plane pixel colour selector, top level.
// Two-stage pipeline: stage 1 waits for the palette read (one cycle of latency,
// data held while no new read is issued), stage 2 is the output register.
// Back-pressure stalls both stages and the input together.
module pxm_selector
    import pxm_pkg::*;
#(
    parameter int STRIDE = 1024,
    parameter int MAX_H  = 768,
    parameter int IDX_W  = 8,
    localparam int XW = $clog2(STRIDE),
    localparam int YW = $clog2(MAX_H + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_bgr,
    input  logic [XW:0]       cfg_width,
    input  logic [YW-1:0]     cfg_height,
    input  logic              in_valid,
    output logic              in_ready,
    input  logic [IDX_W-1:0]  in_index,
    input  logic [PIX_W-1:0]  in_direct,
    input  logic [PIX_W-1:0]  in_ctrl,
    output logic              pal_rd_en,
    output logic [IDX_W-1:0]  pal_rd_addr,
    input  logic [3*CH_W-1:0] pal_rd_data,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [PIX_W-1:0]  out_pixel,
    output logic              out_sol,
    output logic              out_sof
);
    logic accept, visible, line_start, frame_start;
    logic adv1, adv2;
    logic dec_direct;
    rgb_t dec_rgb;

    logic s1_valid, s1_direct, s1_sol, s1_sof;
    rgb_t s1_rgb;
    logic [PIX_W-1:0] s1_pixel;

    logic unused_bits;
    assign unused_bits = ^{in_ctrl[PIX_W-CH_W-1:0], in_direct[PIX_W-1 -: CH_W]};

    assign adv2     = !out_valid || out_ready;
    assign adv1     = !s1_valid || adv2;
    assign in_ready = adv1;
    assign accept   = in_valid && adv1;

    assign pal_rd_en   = accept && visible;
    assign pal_rd_addr = in_index;

    pxm_pos_counter #(.STRIDE(STRIDE), .MAX_H(MAX_H)) u_pos (
        .clk         (clk),
        .rst_n       (rst_n),
        .step        (accept),
        .cfg_width   (cfg_width),
        .cfg_height  (cfg_height),
        .visible     (visible),
        .line_start  (line_start),
        .frame_start (frame_start)
    );

    pxm_mode_decode u_dec (
        .ctrl_tag    (in_ctrl[PIX_W-1 -: CH_W]),
        .direct_word (in_direct[3*CH_W-1:0]),
        .use_direct  (dec_direct),
        .direct_rgb  (dec_rgb)
    );

    pxm_pack u_pack (
        .use_direct (s1_direct),
        .direct_rgb (s1_rgb),
        .pal_rgb    (rgb_t'(pal_rd_data)),
        .bgr        (cfg_bgr),
        .pixel      (s1_pixel)
    );

    // Stage 1: hold mode, direct colour and flags while the palette answers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_valid  <= 1'b0;
            s1_direct <= 1'b0;
            s1_rgb    <= '0;
            s1_sol    <= 1'b0;
            s1_sof    <= 1'b0;
        end else if (adv1) begin
            s1_valid <= accept && visible;
            if (accept && visible) begin
                s1_direct <= dec_direct;
                s1_rgb    <= dec_rgb;
                s1_sol    <= line_start;
                s1_sof    <= frame_start;
            end
        end
    end

    // Stage 2: output register, loaded when the sink can take a new pixel.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0;
            out_pixel <= '0;
            out_sol   <= 1'b0;
            out_sof   <= 1'b0;
        end else if (adv2) begin
            out_valid <= s1_valid;
            if (s1_valid) begin
                out_pixel <= s1_pixel;
                out_sol   <= s1_sol;
                out_sof   <= s1_sof;
            end
        end
    end

    p_reset_idle_r1: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> !out_valid);

    p_hold_out_r8: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && !out_ready |=> out_valid && $stable(out_pixel)
                                   && $stable(out_sol) && $stable(out_sof));

    p_full_rate_r9: assert property (@(posedge clk) disable iff (!rst_n)
        out_ready |-> in_ready);

    p_sof_is_sol_r6: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid && out_sof |-> out_sol);

    p_read_on_accept_r7: assert property (@(posedge clk) disable iff (!rst_n)
        pal_rd_en |-> in_valid && in_ready);
endmodule

// File: tb/sim_pxm_selector.sv
`timescale 1ns/1ps
module sim_pxm_selector;
    localparam int STRIDE = 1024;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cfg_bgr = 1'b0;
    logic [10:0] cfg_width = 11'd1024;
    logic [9:0]  cfg_height = 10'd1;
    logic        in_valid = 1'b0;
    logic        in_ready;
    logic [7:0]  in_index = '0;
    logic [31:0] in_direct = '0;
    logic [31:0] in_ctrl = '0;
    logic        pal_rd_en;
    logic [7:0]  pal_rd_addr;
    logic [23:0] pal_rd_data;
    logic        out_valid;
    logic        out_ready = 1'b0;
    logic [31:0] out_pixel;
    logic        out_sol, out_sof;

    int checks = 0;
    int fails  = 0;

    logic [23:0] pal_mem [256];
    logic [23:0] pal_q = '0;
    logic [35:0] expq [$];

    always #2.5 clk = ~clk;

    pxm_selector u0 (
        .clk(clk), .rst_n(rst_n), .cfg_bgr(cfg_bgr), .cfg_width(cfg_width),
        .cfg_height(cfg_height), .in_valid(in_valid), .in_ready(in_ready),
        .in_index(in_index), .in_direct(in_direct), .in_ctrl(in_ctrl),
        .pal_rd_en(pal_rd_en), .pal_rd_addr(pal_rd_addr), .pal_rd_data(pal_rd_data),
        .out_valid(out_valid), .out_ready(out_ready), .out_pixel(out_pixel),
        .out_sol(out_sol), .out_sof(out_sof)
    );

    // Palette RAM model: one cycle of latency, output held without a read.
    always_ff @(posedge clk) if (pal_rd_en) pal_q <= pal_mem[pal_rd_addr];
    assign pal_rd_data = pal_q;

    task automatic check(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Expected packed colour from the requirement rules (R2, R3, R4).
    function automatic logic [31:0] exp_pixel(input logic [31:0] ctrl, input logic [31:0] dir,
                                              input logic [7:0] idx, input logic bgr);
        logic [7:0] r, g, b;
        if (ctrl[31:24] == 8'h03) begin
            b = dir[23:16]; g = dir[15:8]; r = dir[7:0];
        end else begin
            r = pal_mem[idx][23:16]; g = pal_mem[idx][15:8]; b = pal_mem[idx][7:0];
        end
        return bgr ? {8'h00, b, g, r} : {8'h00, r, g, b};
    endfunction

    task automatic do_reset(input int w, input int h, input bit bgr);
        rst_n = 1'b0;
        in_valid = 1'b0;
        out_ready = 1'b0;
        cfg_width = 11'(w);
        cfg_height = 10'(h);
        cfg_bgr = bgr;
        repeat (3) @(negedge clk);
        #1;
        check(!out_valid && in_ready && !pal_rd_en, "R1 in reset",
              {out_valid, in_ready, pal_rd_en}, 3'b010);
        @(negedge clk);
        rst_n = 1'b1;
        #1;
        check(!out_valid && in_ready && !pal_rd_en, "R1 after reset",
              {out_valid, in_ready, pal_rd_en}, 3'b010);
    endtask

    task automatic run_segment(input int w, input int h, input bit bgr, input int frames,
                               input int vpct, input int rpct);
        int total = frames * h * STRIDE;
        int sent = 0;
        int bx = 0;
        int by = 0;
        int n = 0;
        int stalls = 0;
        int idle = 0;
        bit have = 0;
        logic [7:0] corner [4] = '{8'h02, 8'h04, 8'h83, 8'hFF};
        do_reset(w, h, bgr);
        while (idle < 8) begin
            @(negedge clk);
            out_ready = (($urandom % 100) < rpct);
            if (!have && sent < total && (($urandom % 100) < vpct)) begin
                have = 1;
                n++;
                in_index  = 8'($urandom);
                in_direct = $urandom;
                in_ctrl   = $urandom;
                if (n % 3 == 0) in_ctrl[31:24] = 8'h03;
                if (n % 7 == 0) in_ctrl[31:24] = corner[(n / 7) % 4];
            end
            in_valid = have;
            #1;
            if (vpct == 100 && rpct == 100 && sent > 0 && sent < total && !in_ready) stalls++;
            if (in_valid && in_ready) begin
                if (bx < w) begin
                    check(pal_rd_en && pal_rd_addr == in_index, "R7 read on visible",
                          {pal_rd_en, pal_rd_addr}, {1'b1, in_index});
                    expq.push_back({2'b00, bx == 0, bx == 0 && by == 0,
                                    exp_pixel(in_ctrl, in_direct, in_index, bgr)});
                end else begin
                    check(!pal_rd_en, "R5 no read past width", pal_rd_en, 0);
                end
                bx++;
                if (bx == STRIDE) begin
                    bx = 0;
                    by = (by == h - 1) ? 0 : by + 1;
                end
                sent++;
                have = 0;
            end
            if (out_valid && out_ready) begin
                if (expq.size() == 0) begin
                    check(0, "R5 extra output", out_pixel, 0);
                end else begin
                    logic [35:0] e = expq.pop_front();
                    check(out_pixel == e[31:0], "R2/R3/R4 pixel colour", out_pixel, e[31:0]);
                    check({out_sol, out_sof} == e[33:32], "R6 line/frame flags",
                          {out_sol, out_sof}, e[33:32]);
                end
            end
            if (sent >= total && expq.size() == 0 && !out_valid) idle++;
        end
        in_valid = 1'b0;
        check(expq.size() == 0, "R5 missing outputs", expq.size(), 0);
        if (vpct == 100 && rpct == 100)
            check(stalls == 0, "R9 full rate input", stalls, 0);
    endtask

    // R8 directed: hold output under a long stall, then confirm nothing is lost.
    task automatic stall_hold;
        logic [31:0] p0;
        logic [1:0]  f0;
        do_reset(4, 1, 1'b0);
        for (int i = 0; i < 3; i++) begin
            @(negedge clk);
            in_valid = 1'b1;
            in_index = 8'(i + 10);
            in_ctrl = 32'h0000_0000;
            in_direct = 32'h0;
            #1;
            if (in_ready) expq.push_back({2'b00, i == 0, i == 0, exp_pixel(in_ctrl, in_direct, in_index, 1'b0)});
        end
        @(negedge clk);
        in_valid = 1'b0;
        repeat (3) @(negedge clk);
        #1;
        p0 = out_pixel;
        f0 = {out_sol, out_sof};
        repeat (10) @(negedge clk);
        #1;
        check(out_valid && out_pixel == p0 && {out_sol, out_sof} == f0, "R8 hold under stall",
              out_pixel, p0);
        while (expq.size() != 0) begin
            @(negedge clk);
            out_ready = 1'b1;
            #1;
            if (out_valid) begin
                logic [35:0] e = expq.pop_front();
                check(out_pixel == e[31:0] && {out_sol, out_sof} == e[33:32], "R8 no loss after stall",
                      out_pixel, e[31:0]);
            end
        end
    endtask

    // Watchdog: a hung run is a failure but still reports.
    initial begin
        repeat (200000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired actual=hung expected=done");
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end

    initial begin
        void'($urandom(32'd20240611));
        for (int i = 0; i < 256; i++) pal_mem[i] = 24'($urandom);
        run_segment(1024, 2, 1'b0, 2, 100, 100);
        run_segment(1, 3, 1'b1, 2, 90, 70);
        run_segment(37, 2, 1'b0, 2, 60, 40);
        run_segment(500, 1, 1'b1, 2, 80, 85);
        stall_hold();
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    end
endmodule